// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status flags of an asynchronous serial port. It sits between the receive and transmit shift engines and the CPU register bus. It turns the engines' per-character event strobes into five sticky flags: transmit buffer empty, transmit finished, receive buffer full, parity error and received multiprocessor bit. It presents these flags as one 8-bit status word.

Software clears a clearable flag in two steps. It first reads the flag as 1, and then writes 0 to that flag's bit. A parity error still lets the faulty character reach the receive data register, through the load strobe. The error then stops all further reception until software clears it. A hardware agent that writes the transmit data register clears the transmit flags directly, as software would.

Top module: `serial_status_flags`

## Requirements
- R1: After reset the status word is 0x84: transmit-empty (bit 7) and transmit-finished (bit 2) are 1, receive-full (bit 6), parity-error (bit 3) and multiprocessor-bit (bit 1) are 0, and `halt_rx_o` is 0.
- R2: With `par_en_i` high, an accepted character sets the parity-error bit when the XOR of `rx_data_i` and `rx_par_i` differs from `par_odd_i` (0 = even, 1 = odd). The character is still loaded (`rx_load_o` high in the strobe cycle), but receive-full is not set.
- R3: An accepted character without a parity error sets receive-full on the next edge and raises `rx_load_o` combinationally in the strobe cycle.
- R4: `halt_rx_o` equals the parity-error bit. While it is 1, `rx_done_i` is ignored: there is no load, and receive-full and the multiprocessor bit are unchanged.
- R5: Bits 7, 6 and 3 are cleared by a bus write of 0 to that bit only if a bus read has returned 1 for that bit since the last write. Any write disarms all bits. A write of 0 without the prior read, or a write of 1, changes nothing.
- R6: Bits 2 and 1 are read-only and ignore bus writes. Bits 5, 4 and 0 always read 0.
- R7: While `rx_en_i` is 0, `rx_done_i` is ignored, so the parity-error and multiprocessor bits keep their values.
- R8: In multiprocessor format (`mp_fmt_i` = 1), each accepted character copies `rx_mpb_i` into bit 1. Outside that format, bit 1 is unchanged.
- R9: `tx_en_i` = 0 sets both transmit bits. `tx_last_bit_i` sets transmit-finished when transmit-empty is 1, and sets transmit-empty when it is 0.
- R10: A software clear of transmit-empty, or a pulse on `tx_dma_wr_i`, clears both transmit-empty and transmit-finished.
- R11: When a set event and a clear meet in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| mp_fmt_i | input | 1 | Multiprocessor character format |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | Parity sense, 1 = odd |
| rx_done_i | input | 1 | Receive engine finished a character |
| rx_data_i | input | DATA_W | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| tx_last_bit_i | input | 1 | Transmit engine shifting out the final bit |
| tx_dma_wr_i | input | 1 | Hardware write of the transmit data register |
| bus_rd_i | input | 1 | Status register read strobe |
| bus_wr_i | input | 1 | Status register write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Status word |
| rx_load_o | output | 1 | Load received character into receive data register |
| halt_rx_o | output | 1 | Reception stalled by parity error |

## Verification
The hardest situations to reach are the ones where the read-arm state matters. These include a write that lands many cycles after the arming read, a second write that follows without a new read, and a clear that meets a set event in the same edge. Directed sequences build each of these situations step by step. After that, a long random run with frequent reads and writes, random write data and occasional enable drops mixes arming, disarming and hardware events in every order, and a cycle-accurate bench model checks each step.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_TXE  = 7;
  localparam int unsigned BIT_RXF  = 6;
  localparam int unsigned BIT_PERR = 3;
  localparam int unsigned BIT_TXD  = 2;
  localparam int unsigned BIT_MPB  = 1;

  // software-clearable flags, index into the arm tracker
  localparam int unsigned N_CLR    = 3;
  localparam int unsigned CI_TXE   = 0;
  localparam int unsigned CI_RXF   = 1;
  localparam int unsigned CI_PERR  = 2;

  localparam int unsigned CLR_BIT [N_CLR] = '{BIT_TXE, BIT_RXF, BIT_PERR};

  typedef struct packed {
    logic tx_empty;
    logic rx_full;
    logic par_err;
    logic tx_done;
    logic mp_bit;
  } flags_t;
endpackage

// File: rtl/ssf_arm_tracker.sv
module ssf_arm_tracker #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] wzero_i,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_arm
    // write uses the arm state from before this cycle's read
    assign clr_o[i] = wr_i & arm_q[i] & wzero_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   arm_q[i] <= 1'b0;
      else if (rd_i) arm_q[i] <= flag_i[i];
      else if (wr_i) arm_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ssf_rx_flags.sv
module ssf_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_fmt_i,
  input  logic              rx_mpb_i,
  input  logic              clr_full_i,
  input  logic              clr_perr_i,
  output logic              rx_full_o,
  output logic              par_err_o,
  output logic              mp_bit_o,
  output logic              rx_load_o,
  output logic              halt_o
);
  logic full_q, perr_q, mpb_q;
  logic accept, mismatch;

  assign accept   = rx_en_i & rx_done_i & ~perr_q;
  assign mismatch = par_en_i & ((^{rx_data_i, rx_par_i}) != par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      perr_q <= 1'b0;
      mpb_q  <= 1'b0;
    end else begin
      if (accept && !mismatch) full_q <= 1'b1;
      else if (clr_full_i)     full_q <= 1'b0;

      if (accept && mismatch)  perr_q <= 1'b1;
      else if (clr_perr_i)     perr_q <= 1'b0;

      if (accept && mp_fmt_i)  mpb_q  <= rx_mpb_i;
    end
  end

  assign rx_full_o = full_q;
  assign par_err_o = perr_q;
  assign mp_bit_o  = mpb_q;
  assign rx_load_o = accept;
  assign halt_o    = perr_q;
endmodule

// File: rtl/ssf_tx_flags.sv
module ssf_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic tx_last_i,
  input  logic tx_hw_wr_i,
  input  logic clr_empty_i,
  output logic tx_empty_o,
  output logic tx_done_o
);
  logic empty_q, done_q;
  logic clr_any, set_empty, set_done;

  assign clr_any   = clr_empty_i | tx_hw_wr_i;
  // last bit with a pending character: it moves to the shifter, buffer frees
  assign set_empty = ~tx_en_i | (tx_last_i & ~empty_q);
  assign set_done  = ~tx_en_i | (tx_last_i &  empty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      if (set_empty)    empty_q <= 1'b1;
      else if (clr_any) empty_q <= 1'b0;

      if (set_done)     done_q  <= 1'b1;
      else if (clr_any) done_q  <= 1'b0;
    end
  end

  assign tx_empty_o = empty_q;
  assign tx_done_o  = done_q;
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
  import ssf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              mp_fmt_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_mpb_i,
  input  logic              tx_last_bit_i,
  input  logic              tx_dma_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              rx_load_o,
  output logic              halt_rx_o
);
  flags_t           fl;
  logic [N_CLR-1:0] clr_flag, wzero, clr_req;
  logic             wdata_unused;

  assign wdata_unused = ^{bus_wdata_i[5:4], bus_wdata_i[2:0]};

  always_comb begin
    clr_flag          = '0;
    clr_flag[CI_TXE]  = fl.tx_empty;
    clr_flag[CI_RXF]  = fl.rx_full;
    clr_flag[CI_PERR] = fl.par_err;
  end

  for (genvar i = 0; i < N_CLR; i++) begin : g_wz
    assign wzero[i] = ~bus_wdata_i[CLR_BIT[i]];
  end

  ssf_arm_tracker #(.N(N_CLR)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .flag_i  (clr_flag),
    .wzero_i (wzero),
    .clr_o   (clr_req)
  );

  ssf_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en_i),
    .rx_done_i  (rx_done_i),
    .rx_data_i  (rx_data_i),
    .rx_par_i   (rx_par_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .mp_fmt_i   (mp_fmt_i),
    .rx_mpb_i   (rx_mpb_i),
    .clr_full_i (clr_req[CI_RXF]),
    .clr_perr_i (clr_req[CI_PERR]),
    .rx_full_o  (fl.rx_full),
    .par_err_o  (fl.par_err),
    .mp_bit_o   (fl.mp_bit),
    .rx_load_o  (rx_load_o),
    .halt_o     (halt_rx_o)
  );

  ssf_tx_flags u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .tx_last_i   (tx_last_bit_i),
    .tx_hw_wr_i  (tx_dma_wr_i),
    .clr_empty_i (clr_req[CI_TXE]),
    .tx_empty_o  (fl.tx_empty),
    .tx_done_o   (fl.tx_done)
  );

  always_comb begin
    bus_rdata_o          = '0;
    bus_rdata_o[BIT_TXE]  = fl.tx_empty;
    bus_rdata_o[BIT_RXF]  = fl.rx_full;
    bus_rdata_o[BIT_PERR] = fl.par_err;
    bus_rdata_o[BIT_TXD]  = fl.tx_done;
    bus_rdata_o[BIT_MPB]  = fl.mp_bit;
  end
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       rx_en_i,
  input logic       rx_done_i,
  input logic       mp_fmt_i,
  input logic       tx_last_bit_i,
  input logic       tx_dma_wr_i,
  input logic [7:0] bus_rdata_o,
  input logic       rx_load_o,
  input logic       halt_rx_o
);
  a_r4_halt_is_perr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_rx_o == bus_rdata_o[3]);

  a_r4_no_load_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_rx_o |-> !rx_load_o);

  a_r6_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[5:4] == 2'b00 && !bus_rdata_o[0]);

  a_r6_mpb_only_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_en_i && rx_done_i && mp_fmt_i) |=> $stable(bus_rdata_o[1]));

  a_r7_perr_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !bus_rdata_o[3]) |=> !bus_rdata_o[3]);

  a_r9_tx_off_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> bus_rdata_o[7] && bus_rdata_o[2]);

  a_r10_dma_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_wr_i && tx_en_i && !tx_last_bit_i) |=> !bus_rdata_o[7] && !bus_rdata_o[2]);
endmodule

bind serial_status_flags ssf_checker u_chk (.*);

// File: tb/tb_serial_status_flags.sv
`timescale 1ns/1ps
module tb_serial_status_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en, rx_en, mp, pen, podd, done, par, mpb, last, dma, rd, wr;
  logic [7:0] data, wd, rdata;
  logic load, halt;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // bench model
  logic m_txe, m_rxf, m_perr, m_txd, m_mpb;
  logic [2:0] m_arm;
  logic m_load;

  always #10 clk = ~clk;

  serial_status_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en), .mp_fmt_i(mp),
    .par_en_i(pen), .par_odd_i(podd), .rx_done_i(done), .rx_data_i(data),
    .rx_par_i(par), .rx_mpb_i(mpb), .tx_last_bit_i(last), .tx_dma_wr_i(dma),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .rx_load_o(load), .halt_rx_o(halt));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tx_en = 1; rx_en = 1; mp = 0; pen = 0; podd = 0; done = 0; par = 0;
    mpb = 0; last = 0; dma = 0; rd = 0; wr = 0; data = 8'h00; wd = 8'h00;
  endtask

  function automatic logic [7:0] m_word();
    return {m_txe, m_rxf, 2'b00, m_perr, m_txd, m_mpb, 1'b0};
  endfunction

  // inputs already applied at a negedge; advance one edge and compare
  task automatic step();
    logic acc, mis, c_txe, c_rxf, c_perr, s_txe, s_txd;
    logic n_txe, n_rxf, n_perr, n_txd, n_mpb;
    logic [2:0] n_arm;
    #1;
    acc = rx_en & done & ~m_perr;
    mis = pen & ((^data ^ par) != podd);
    chk("R2 R3 load", {7'd0, load}, {7'd0, acc});
    c_txe  = wr & m_arm[0] & ~wd[7];
    c_rxf  = wr & m_arm[1] & ~wd[6];
    c_perr = wr & m_arm[2] & ~wd[3];
    s_txe  = ~tx_en | (last & ~m_txe);
    s_txd  = ~tx_en | (last & m_txe);
    n_txe  = s_txe ? 1'b1 : ((c_txe | dma) ? 1'b0 : m_txe);
    n_txd  = s_txd ? 1'b1 : ((c_txe | dma) ? 1'b0 : m_txd);
    n_rxf  = (acc & ~mis) ? 1'b1 : (c_rxf ? 1'b0 : m_rxf);
    n_perr = (acc & mis) ? 1'b1 : (c_perr ? 1'b0 : m_perr);
    n_mpb  = (acc & mp) ? mpb : m_mpb;
    n_arm  = rd ? {m_perr, m_rxf, m_txe} : (wr ? 3'b000 : m_arm);
    @(posedge clk);
    @(negedge clk);
    {m_txe, m_rxf, m_perr, m_txd, m_mpb, m_arm} = {n_txe, n_rxf, n_perr, n_txd, n_mpb, n_arm};
    chk("R9 txe",  {7'd0, rdata[7]}, {7'd0, m_txe});
    chk("R3 rxf",  {7'd0, rdata[6]}, {7'd0, m_rxf});
    chk("R2 perr", {7'd0, rdata[3]}, {7'd0, m_perr});
    chk("R10 txd", {7'd0, rdata[2]}, {7'd0, m_txd});
    chk("R8 mpb",  {7'd0, rdata[1]}, {7'd0, m_mpb});
    chk("R6 unused", {5'd0, rdata[5:4], rdata[0]}, 8'h00);
    chk("R4 halt", {7'd0, halt}, {7'd0, m_perr});
    idle();
  endtask

  task automatic clr_sw(input logic [7:0] w);
    rd = 1; step();
    wr = 1; wd = w; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    {m_txe, m_rxf, m_perr, m_txd, m_mpb, m_arm} = {5'b10010, 3'b000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", rdata, 8'h84);
    chk("R1 reset halt", {7'd0, halt}, 8'h00);

    wr = 1; wd = 8'h00; step();
    chk("R5 write without read", rdata, 8'h84);
    clr_sw(8'h00);
    chk("R5 R10 handshake clears tx", rdata, 8'h00);
    rd = 1; step(); wr = 1; wd = 8'hFF; step();
    chk("R6 read-only bits", rdata, 8'h00);

    pen = 1; done = 1; data = 8'h03; par = 0; step();
    chk("R3 good char", rdata, 8'h40);
    clr_sw(8'hBF);
    chk("R5 rxf clear", rdata, 8'h00);

    pen = 1; done = 1; data = 8'h01; par = 0; #1;
    chk("R2 bad char still loads", {7'd0, load}, 8'h01);
    step();
    chk("R2 perr no rxf", rdata, 8'h08);
    chk("R4 halt on", {7'd0, halt}, 8'h01);
    pen = 1; done = 1; data = 8'h03; mp = 1; mpb = 1; #1;
    chk("R4 no load halted", {7'd0, load}, 8'h00);
    step();
    chk("R4 halted ignores char", rdata, 8'h08);
    clr_sw(8'h00);
    chk("R5 perr clear", rdata, 8'h00);

    rx_en = 0; pen = 1; done = 1; data = 8'h01; mp = 1; mpb = 1; step();
    chk("R7 rx off ignores", rdata, 8'h00);

    pen = 1; podd = 1; done = 1; data = 8'h03; par = 0; step();
    chk("R2 odd mismatch", rdata, 8'h08);
    clr_sw(8'h00);
    pen = 1; podd = 1; done = 1; data = 8'h03; par = 1; step();
    chk("R3 odd good", rdata, 8'h40);
    clr_sw(8'h00);

    mp = 1; done = 1; mpb = 1; step();
    chk("R8 mpb set", rdata, 8'h42);
    mp = 1; done = 1; mpb = 0; step();
    chk("R8 mpb clear", rdata, 8'h40);
    mp = 0; done = 1; mpb = 1; step();
    chk("R8 mpb held outside format", rdata, 8'h40);
    clr_sw(8'h00);

    last = 1; step();
    chk("R9 last frees buffer", rdata, 8'h80);
    last = 1; step();
    chk("R9 last sets finished", rdata, 8'h84);
    dma = 1; step();
    chk("R10 dma clears", rdata, 8'h00);
    tx_en = 0; step();
    chk("R9 tx off sets", rdata, 8'h84);

    rd = 1; step();
    wr = 1; wd = 8'h00; tx_en = 0; step();
    chk("R11 set beats clear tx", rdata, 8'h84);
    wr = 1; wd = 8'h00; step();
    chk("R5 disarmed after write", rdata, 8'h84);

    done = 1; step();
    chk("R3 rxf with tx", rdata, 8'hC4);
    rd = 1; step();
    wr = 1; wd = 8'h00; done = 1; step();
    chk("R11 set beats clear rx", rdata, 8'h40);

    for (int n = 0; n < 4000; n++) begin
      tx_en = ($urandom_range(0, 19) != 0);
      rx_en = ($urandom_range(0, 9) != 0);
      mp    = $urandom_range(0, 1);
      pen   = $urandom_range(0, 1);
      podd  = $urandom_range(0, 1);
      done  = ($urandom_range(0, 3) == 0);
      data  = 8'($urandom);
      par   = $urandom_range(0, 1);
      mpb   = $urandom_range(0, 1);
      last  = ($urandom_range(0, 5) == 0);
      dma   = ($urandom_range(0, 7) == 0);
      rd    = ($urandom_range(0, 9) < 3);
      wr    = ($urandom_range(0, 9) < 3);
      wd    = 8'($urandom);
      step();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule